// File: doc/BRIEF.md
# Port Pin Mismatch Change Detector

This block watches the upper half of an 8-bit input port and raises an interrupt flag when any of those pins no longer matches the value that software last saw. Every port read captures the synchronized pin values into a held copy. The flag is set on every cycle in which the live upper pins differ from that copy. A change therefore shows up as a standing mismatch, not as a single-cycle edge. It keeps asserting the flag until software reads the port, and only then can a clear take hold.

Raw pins first pass through a multi-stage synchronizer. The comparison, the held copy and the read data all use the synchronized values. The flag is always recorded, whatever the local enable is set to, so software can poll it. The enable only gates the interrupt request that goes to the rest of the interrupt logic. After reset, the held copy is seeded from the synchronized pins, so a port that comes up with static nonzero levels does not report a change.

Top module: `pmcd_top`

## Requirements
- R1: While reset is asserted, `flag_o`, `irq_o` and `rd_data_o` are all 0.
- R2: When any of pins 7 to 4 differs from the held copy, `flag_o` reads 1 three clock edges after the pin change: two synchronizer edges and one flag edge.
- R3: Changes on pins 3 to 0 never set `flag_o`.
- R4: While the mismatch persists, a pulse on `clr_i` does not clear `flag_o`.
- R5: A pulse on `rd_stb_i` places the synchronized 8-bit port value on `rd_data_o` one edge later and loads pins 7 to 4 into the held copy. A `clr_i` pulse after that clears `flag_o`.
- R6: `flag_o` is set whether `en_i` is 0 or 1. `irq_o` is 1 only when both `flag_o` and `en_i` are 1.
- R7: When the pins hold static nonzero levels through and after reset, no flag is raised, because the held copy is seeded from the synchronized pins in the first SYNC_STAGES+1 edges after reset.
- R8: A read in the first cycle in which the synchronized value differs still sets the flag in that cycle and captures the new value. A later clear takes hold, and any later change sets the flag again.
- R9: With no mismatch, a `clr_i` pulse drives `flag_o` to 0 on the next edge. A clear while `flag_o` is already 0 leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Raw port pin levels |
| rd_stb_i | input | 1 | Port read strobe, one cycle |
| rd_data_o | output | 8 | Synchronized port value captured at the last read |
| clr_i | input | 1 | Software clear of the flag |
| en_i | input | 1 | Local interrupt enable |
| flag_o | output | 1 | Change flag |
| irq_o | output | 1 | Interrupt request, the flag gated by the enable |

## Verification
A pin change reaches `flag_o` after three rising edges: two synchronizer stages and then the flag register. `rd_data_o` and the held copy update one edge after the read strobe, and a clear acts one edge after it is applied. `irq_o` follows `en_i` in the same cycle. Every vector holds a new pin value for three edges, then pulses the read strobe and the clear in separate cycles, and samples on the falling edge after the last of these. The directed tests for reset seeding and for a read in the same cycle as a change count edges in the same way before each sample.

// File: rtl/pmcd_pkg.sv
package pmcd_pkg;
  localparam int unsigned DEF_PORT_W      = 8;
  localparam int unsigned DEF_MON_LO      = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned CMP_MAX_W       = 32;

  // Any bit of the live slice differs from the held slice
  function automatic logic slice_differs(input logic [CMP_MAX_W-1:0] live,
                                         input logic [CMP_MAX_W-1:0] held);
    return |(live ^ held);
  endfunction

  // Edges after reset during which the held copy follows the synchronizer
  function automatic int unsigned seed_edges(input int unsigned stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/pmcd_sync.sv
module pmcd_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pmcd_snapshot.sv
module pmcd_snapshot #(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned MON_LO   = 4,
  parameter int unsigned SEED_LEN = 3,
  localparam int unsigned MON_W   = PORT_W - MON_LO,
  localparam int unsigned CNT_W   = $clog2(SEED_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] sync_i,
  input  logic              rd_i,
  output logic [MON_W-1:0]  held_o,
  output logic [PORT_W-1:0] rd_data_o,
  output logic              seed_o
);
  logic [CNT_W-1:0]  seed_cnt_q;
  logic [MON_W-1:0]  held_q;
  logic [PORT_W-1:0] rd_data_q;

  assign seed_o = (seed_cnt_q != CNT_W'(SEED_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seed_cnt_q <= '0;
    else if (seed_o) seed_cnt_q <= seed_cnt_q + 1'b1;
  end

  // Held copy follows the synchronizer while seeding, then only on reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             held_q <= '0;
    else if (seed_o || rd_i) held_q <= sync_i[PORT_W-1:MON_LO];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_q <= '0;
    else if (rd_i) rd_data_q <= sync_i;
  end

  assign held_o    = held_q;
  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/pmcd_flag.sv
module pmcd_flag #(
  parameter int unsigned MON_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MON_W-1:0] live_i,
  input  logic [MON_W-1:0] held_i,
  input  logic             seed_i,
  input  logic             clr_i,
  output logic             mismatch_o,
  output logic             flag_o
);
  import pmcd_pkg::*;

  logic flag_q;

  assign mismatch_o = !seed_i &&
                      slice_differs(CMP_MAX_W'(live_i), CMP_MAX_W'(held_i));

  // A standing mismatch wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (mismatch_o) flag_q <= 1'b1;
    else if (clr_i)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pmcd_top.sv
module pmcd_top #(
  parameter int unsigned PORT_W      = pmcd_pkg::DEF_PORT_W,
  parameter int unsigned MON_LO      = pmcd_pkg::DEF_MON_LO,
  parameter int unsigned SYNC_STAGES = pmcd_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pins_i,
  input  logic              rd_stb_i,
  output logic [PORT_W-1:0] rd_data_o,
  input  logic              clr_i,
  input  logic              en_i,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int unsigned MON_W    = PORT_W - MON_LO;
  localparam int unsigned SEED_LEN = pmcd_pkg::seed_edges(SYNC_STAGES);

  // Named internal events, visible to the bound checker
  logic [PORT_W-1:0] sync_q;
  logic [MON_W-1:0]  held_q;
  logic              seed_active;
  logic              mismatch;
  logic              flag_q;

  pmcd_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (sync_q)
  );

  pmcd_snapshot #(.PORT_W(PORT_W), .MON_LO(MON_LO), .SEED_LEN(SEED_LEN)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_q),
    .rd_i     (rd_stb_i),
    .held_o   (held_q),
    .rd_data_o(rd_data_o),
    .seed_o   (seed_active)
  );

  pmcd_flag #(.MON_W(MON_W)) u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .live_i    (sync_q[PORT_W-1:MON_LO]),
    .held_i    (held_q),
    .seed_i    (seed_active),
    .clr_i     (clr_i),
    .mismatch_o(mismatch),
    .flag_o    (flag_q)
  );

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/pmcd_checker.sv
module pmcd_checker #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned MON_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_stb_i,
  input logic              clr_i,
  input logic              en_i,
  input logic              flag_o,
  input logic              irq_o,
  input logic [PORT_W-1:0] rd_data_o,
  input logic [PORT_W-1:0] sync_q,
  input logic [MON_W-1:0]  held_q,
  input logic              seed_active,
  input logic              mismatch
);
  p_set_on_mismatch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch |=> flag_o);

  p_no_set_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !mismatch) |=> !flag_o);

  p_hold_without_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  p_read_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> (rd_data_o == $past(sync_q)));

  p_read_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> (held_q == $past(sync_q[PORT_W-1:PORT_W-MON_W])));

  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);

  p_seed_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_active |-> !mismatch);

  p_clear_takes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !mismatch) |=> !flag_o);
endmodule

bind pmcd_top pmcd_checker #(.PORT_W(PORT_W), .MON_W(MON_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_stb_i   (rd_stb_i),
  .clr_i      (clr_i),
  .en_i       (en_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .rd_data_o  (rd_data_o),
  .sync_q     (sync_q),
  .held_q     (held_q),
  .seed_active(seed_active),
  .mismatch   (mismatch)
);

// File: tb/pmcd_top_tb.sv
module pmcd_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 14;

  typedef struct packed {
    logic [7:0] pins;
    logic       rd;
    logic       clr;
    logic       en;
    logic       eflag;
    logic       eirq;
    logic [7:0] erd;
  } vec_t;

  // pins, read, clear, enable, expected flag, irq, read data
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 idle
    '{8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 low pins only
    '{8'h15, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R2/R6 set, enable off
    '{8'h15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00}, // R4 clear ignored
    '{8'h15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h15}, // R5 read then clear
    '{8'h1A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h15}, // R3
    '{8'h9A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h15}, // R2 bit 7
    '{8'h9A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h9A}, // R5 read alone keeps flag
    '{8'h9A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h9A}, // R9 clear
    '{8'h9A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h9A}, // R9 clear while 0
    '{8'h1A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9A}, // R2 falling pin, R6
    '{8'h1A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h1A}, // R5
    '{8'hF0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h1A}, // R2 several pins
    '{8'hF0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF0}  // R5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       rd_stb = 1'b0;
  logic       clr = 1'b0;
  logic       en = 1'b0;
  logic [7:0] rd_data;
  logic       flag;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmcd_top u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pins_i   (pins),
    .rd_stb_i (rd_stb),
    .rd_data_o(rd_data),
    .clr_i    (clr),
    .en_i     (en),
    .flag_o   (flag),
    .irq_o    (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_read();
    rd_stb = 1'b1; edges(1); rd_stb = 1'b0;
  endtask

  task automatic pulse_clear();
    clr = 1'b1; edges(1); clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    pins = 8'hA5;
    edges(4);
    check("R1", "flag", {7'd0, flag}, 8'h00);
    check("R1", "irq", {7'd0, irq}, 8'h00);
    check("R1", "rd_data", rd_data, 8'h00);
    pins = 8'h00;
    rst_n = 1'b1;
    edges(5);

    // Vector walk: hold pins 3 edges, optional read, optional clear
    for (int i = 0; i < NVEC; i++) begin
      pins = VECS[i].pins;
      en   = VECS[i].en;
      edges(3);
      if (VECS[i].rd)  pulse_read();
      if (VECS[i].clr) pulse_clear();
      check($sformatf("R2-vec%0d", i), "flag", {7'd0, flag}, {7'd0, VECS[i].eflag});
      check($sformatf("R6-vec%0d", i), "irq", {7'd0, irq}, {7'd0, VECS[i].eirq});
      check($sformatf("R5-vec%0d", i), "rd_data", rd_data, VECS[i].erd);
    end

    // R7: static nonzero pins through reset raise no flag
    en = 1'b1;
    rst_n = 1'b0;
    pins = 8'hF3;
    edges(3);
    rst_n = 1'b1;
    edges(8);
    check("R7", "flag", {7'd0, flag}, 8'h00);
    check("R7", "irq", {7'd0, irq}, 8'h00);
    pulse_read();
    check("R7", "rd_data", rd_data, 8'hF3);
    check("R7", "flag after read", {7'd0, flag}, 8'h00);

    // R8: read in the first cycle the synchronized value differs
    pins = 8'h03;
    edges(2);
    pulse_read();
    check("R8", "flag same-cycle", {7'd0, flag}, 8'h01);
    check("R8", "rd_data", rd_data, 8'h03);
    pulse_clear();
    check("R8", "flag cleared", {7'd0, flag}, 8'h00);
    pins = 8'h13;
    edges(2);
    check("R2", "flag not yet", {7'd0, flag}, 8'h00);
    edges(1);
    check("R8", "later change", {7'd0, flag}, 8'h01);

    // R3: low pins alone after a clean read
    pulse_read();
    pulse_clear();
    pins = 8'h1C;
    edges(4);
    check("R3", "flag", {7'd0, flag}, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule